// File: doc/BRIEF.md
# Output-Compare Timer Bank

This block holds a free-running 16-bit up-counter clocked by the bus clock together with a bank of eight output-compare channels. Every channel has its own 16-bit compare value. When a channel is armed and the counter reaches that value, the channel raises a sticky match flag, optionally requests an interrupt, and updates its output pin according to a 2-bit pin action. Software arms an event a fixed number of counts ahead by reading the counter, adding the wanted delay modulo 2^16, and writing the sum as the new compare value.

All configuration goes through a byte-wide register port with a write strobe and a combinational read path. Compare values are loaded with two byte writes. The high byte is held in a per-channel staging register, and the low-byte write moves both bytes into the live compare register at once. This way a half-written value can never produce a match.

Each channel resolves its pin through a small action state set: `PIN_OFF` holds the level and releases the pin, `PIN_TOGGLE` inverts it, `PIN_CLEAR` drives it low and `PIN_SET` drives it high. The only transition is a compare hit, which moves the pin level to the value that the current action selects. Without a hit the level stays where it is.

Top module: `cmp_timer_bank`

## Requirements
- R1: After reset the counter is 0. It increases by one on every clock edge and wraps from 0xFFFF to 0. Its upper byte is read at address 0x04 and its lower byte at 0x05.
- R2: A channel whose arm bit (address 0x00, bit i for channel i) is 0 never sets its flag and never changes its pin.
- R3: An armed channel whose live compare value equals the counter sets its flag bit (address 0x02, bit i) on the next clock edge. The flag is therefore first visible in the cycle where the counter holds compare+1.
- R4: The interrupt output irq[i] is high exactly when flag i is set and interrupt-enable bit i (address 0x01) is 1.
- R5: Writing a byte to address 0x02 clears each flag whose bit in that byte is 1 and leaves flags at 0-bits unchanged. A hit in the same cycle wins over the clear.
- R6: The pin action of channel i sits in the byte at 0x08 + i/2, in bits [1:0] for even i and bits [3:2] for odd i. On a hit, 00 holds the level, 01 toggles it, 10 drives it low and 11 drives it high, starting in the cycle after the hit. pin_en[i] is 1 exactly when the action is not 00.
- R7: The compare high byte of channel i is written at 0x10 + 2i and the low byte at 0x11 + 2i. Only the low-byte write replaces the live compare value, taking the last staged high byte. Until then the old value stays in force.
- R8: Compare matching works across the counter wrap: a value that the scheduling sum wrapped past 0xFFFF matches after the counter rolls over.
- R9: After reset all flags, arm bits, enables, actions and compare values are 0, and all pins, pin enables and interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq | output | 8 | Per-channel interrupt requests |
| pin_out | output | 8 | Per-channel pin levels |
| pin_en | output | 8 | Per-channel pin drive enables |

## Verification
The bench builds the block with its default of eight channels and a 16-bit counter. With these values, the packing of two action fields per byte and the full compare address range are both exercised. A 16-bit counter wraps after 65,536 cycles, which is short enough to reach inside the cycle budget, so a directed case schedules an event across the rollover. Random channel, action, enable and delay choices run alongside directed cases for every pin action, an unarmed channel, the flag-clear semantics and a staged high byte without its low byte.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int ADDR_W  = 6;
    localparam int A_SEL      = 0;
    localparam int A_IEN      = 1;
    localparam int A_FLAG     = 2;
    localparam int A_CNT_HI   = 4;
    localparam int A_CNT_LO   = 5;
    localparam int A_ACT_BASE = 8;
    localparam int A_CMP_BASE = 16;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'b00,
        PIN_TOGGLE = 2'b01,
        PIN_CLEAR  = 2'b10,
        PIN_SET    = 2'b11
    } pin_act_e;
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output logic [BYTE_W-1:0]    bus_rdata,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [NCH-1:0]       flag,
    input  logic [NCH*CNT_W-1:0] cmp_flat,
    output logic [NCH-1:0]       sel,
    output logic [NCH-1:0]       ien,
    output logic [2*NCH-1:0]     act_flat,
    output logic [NCH-1:0]       flag_clr,
    output logic [NCH-1:0]       hi_we,
    output logic [NCH-1:0]       lo_we
);
    localparam int NACT = NCH / 2;

    logic [NCH-1:0]   sel_q, ien_q;
    logic [2*NCH-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ien_q <= '0;
            act_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_SEL)) sel_q <= bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_W'(A_IEN)) ien_q <= bus_wdata[NCH-1:0];
            for (int k = 0; k < NACT; k++) begin
                if (bus_addr == ADDR_W'(A_ACT_BASE + k))
                    act_q[4*k +: 4] <= bus_wdata[3:0];
            end
        end
    end

    always_comb begin
        flag_clr = '0;
        hi_we    = '0;
        lo_we    = '0;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_FLAG)) flag_clr = bus_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                hi_we[i] = (bus_addr == ADDR_W'(A_CMP_BASE + 2*i));
                lo_we[i] = (bus_addr == ADDR_W'(A_CMP_BASE + 2*i + 1));
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_SEL))    bus_rdata[NCH-1:0] = sel_q;
        if (bus_addr == ADDR_W'(A_IEN))    bus_rdata[NCH-1:0] = ien_q;
        if (bus_addr == ADDR_W'(A_FLAG))   bus_rdata[NCH-1:0] = flag;
        if (bus_addr == ADDR_W'(A_CNT_HI)) bus_rdata = cnt[CNT_W-1:BYTE_W];
        if (bus_addr == ADDR_W'(A_CNT_LO)) bus_rdata = cnt[BYTE_W-1:0];
        for (int k = 0; k < NACT; k++) begin
            if (bus_addr == ADDR_W'(A_ACT_BASE + k))
                bus_rdata[3:0] = act_q[4*k +: 4];
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(A_CMP_BASE + 2*i))
                bus_rdata = cmp_flat[i*CNT_W + BYTE_W +: BYTE_W];
            if (bus_addr == ADDR_W'(A_CMP_BASE + 2*i + 1))
                bus_rdata = cmp_flat[i*CNT_W +: BYTE_W];
        end
    end

    assign sel      = sel_q;
    assign ien      = ien_q;
    assign act_flat = act_q;

    // R7
    cmp_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hi_we, lo_we}) <= 1);
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sel,
    input  logic              ien,
    input  logic [1:0]        act,
    input  logic              flag_clr,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic              flag,
    output logic              irq,
    output logic              pin,
    output logic              pin_en,
    output logic [CNT_W-1:0]  cmp_val
);
    logic [BYTE_W-1:0] stage_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              flag_q, pin_q, pin_d, hit;
    pin_act_e          act_e;

    assign act_e = pin_act_e'(act);
    assign hit   = sel && (cnt == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            cmp_q   <= '0;
        end else begin
            if (hi_we) stage_q <= wdata;
            if (lo_we) cmp_q   <= {stage_q, wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    always_comb begin
        pin_d = pin_q;
        if (hit) begin
            unique case (act_e)
                PIN_OFF:    pin_d = pin_q;
                PIN_TOGGLE: pin_d = ~pin_q;
                PIN_CLEAR:  pin_d = 1'b0;
                PIN_SET:    pin_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign flag    = flag_q;
    assign irq     = flag_q & ien;
    assign pin     = pin_q;
    assign pin_en  = (act_e != PIN_OFF);
    assign cmp_val = cmp_q;

    // R3
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cnt == cmp_q) |=> flag_q);
    // R2
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(sel && cnt == cmp_q));
    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(sel && cnt == cmp_q)) |=> !flag_q);
    // R6
    pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cnt == cmp_q && act == 2'b11) |=> pin_q);
    // R6
    pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cnt == cmp_q && act == 2'b01) |=> (pin_q != $past(pin_q)));
    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_we |=> $stable(cmp_q));
endmodule

// File: rtl/cmp_timer_bank.sv
module cmp_timer_bank
    import cmp_timer_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_en
);
    logic [CNT_W-1:0]     cnt;
    logic [NCH-1:0]       sel, ien, flag, flag_clr, hi_we, lo_we;
    logic [2*NCH-1:0]     act_flat;
    logic [NCH*CNT_W-1:0] cmp_flat;

    cmp_timer_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt)
    );

    cmp_timer_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt(cnt), .flag(flag), .cmp_flat(cmp_flat),
        .sel(sel), .ien(ien), .act_flat(act_flat),
        .flag_clr(flag_clr), .hi_we(hi_we), .lo_we(lo_we)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmp_timer_channel u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt),
            .sel(sel[i]), .ien(ien[i]), .act(act_flat[2*i +: 2]),
            .flag_clr(flag_clr[i]), .hi_we(hi_we[i]), .lo_we(lo_we[i]),
            .wdata(bus_wdata),
            .flag(flag[i]), .irq(irq[i]), .pin(pin_out[i]), .pin_en(pin_en[i]),
            .cmp_val(cmp_flat[i*CNT_W +: CNT_W])
        );
    end

    // R4
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~ien) == '0);
endmodule

// File: tb/sim_cmp_timer_bank.sv
module sim_cmp_timer_bank;
    localparam int CLK_P = 10;
    localparam int NCH   = 8;
    localparam logic [5:0] AD_SEL = 6'h00, AD_IEN = 6'h01, AD_FLG = 6'h02,
                           AD_CHI = 6'h04, AD_CLO = 6'h05,
                           AD_ACT = 6'h08, AD_CMP = 6'h10;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [NCH-1:0] irq, pin_out, pin_en;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] mcnt;
    logic [1:0] act_m [NCH];
    bit pin_m [NCH];

    cmp_timer_bank #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .pin_out(pin_out), .pin_en(pin_en)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) mcnt <= 16'h0;
        else        mcnt <= mcnt + 16'h1;
    end

    function automatic bit next_pin(logic [1:0] a, bit prev);
        case (a)
            2'b01:   return ~prev;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return prev;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h at cnt=%0h", req, got, exp, mcnt);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cnt(logic [15:0] v);
        while (mcnt != v) @(negedge clk);
    endtask

    // Arms channel ch (or not), schedules a match d counts ahead, checks the hit.
    task automatic sched(int ch, logic [1:0] a, bit e, bit arm, int d);
        logic [15:0] c;
        logic [7:0] r;
        int k;
        c = mcnt + 16'(d);
        k = ch / 2;
        act_m[ch] = a;
        wr(AD_SEL, arm ? 8'(1 << ch) : 8'h00);
        wr(AD_IEN, e ? 8'(1 << ch) : 8'h00);
        wr(AD_ACT + 6'(k), {4'h0, act_m[2*k+1], act_m[2*k]});
        wr(AD_CMP + 6'(2*ch), c[15:8]);
        wr(AD_CMP + 6'(2*ch + 1), c[7:0]);
        wr(AD_FLG, 8'hFF);
        wait_cnt(c);
        chk("R3 flag low while counter equals compare", irq[ch], 0);
        chk("R6 pin before hit", pin_out[ch], pin_m[ch]);
        @(negedge clk);
        if (arm) pin_m[ch] = next_pin(a, pin_m[ch]);
        chk(arm ? "R4 irq after hit" : "R2 unarmed irq", irq[ch], arm && e);
        chk(arm ? "R6 pin after hit" : "R2 unarmed pin", pin_out[ch], pin_m[ch]);
        chk("R6 pin enable", pin_en[ch], a != 2'b00);
        rd(AD_FLG, r);
        chk(arm ? "R3 flag set" : "R2 unarmed flag", r[ch], arm);
    endtask

    initial begin
        repeat (CLK_P * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, r2;
        logic [15:0] t;
        void'($urandom(32'd4711));
        for (int i = 0; i < NCH; i++) begin act_m[i] = 2'b00; pin_m[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        @(negedge clk);
        chk("R9 irq", irq, 0);
        chk("R9 pins", pin_out, 0);
        chk("R9 pin enables", pin_en, 0);
        rd(AD_SEL, r); chk("R9 arm bits", r, 0);
        rd(AD_FLG, r); chk("R9 flags", r, 0);
        rd(AD_CMP + 6'd7, r); chk("R9 compare", r, 0);

        // R1 counter readback
        rd(AD_CHI, r); chk("R1 counter high", r, mcnt[15:8]);
        rd(AD_CLO, r); chk("R1 counter low", r, mcnt[7:0]);

        // R2 unarmed channel
        sched(2, 2'b11, 1'b1, 1'b0, 30);

        // R6 every action, directed
        sched(3, 2'b11, 1'b1, 1'b1, 25);
        sched(3, 2'b01, 1'b0, 1'b1, 25);
        sched(3, 2'b01, 1'b1, 1'b1, 25);
        sched(3, 2'b00, 1'b1, 1'b1, 25);
        sched(4, 2'b11, 1'b0, 1'b1, 25);
        sched(4, 2'b10, 1'b1, 1'b1, 25);

        // R5 write 0 keeps, write 1 clears
        wr(AD_FLG, 8'h00);
        rd(AD_FLG, r); chk("R5 zero write keeps flag", r[4], 1);
        wr(AD_FLG, 8'h10);
        rd(AD_FLG, r); chk("R5 one write clears flag", r[4], 0);
        chk("R5 irq drops", irq[4], 0);

        // R7 staged high byte without low byte stays out of force
        t = mcnt + 16'd40;
        wr(AD_SEL, 8'h20);
        wr(AD_CMP + 6'd10, t[15:8] + 8'h0A);
        wr(AD_CMP + 6'd11, t[7:0]);
        wr(AD_FLG, 8'hFF);
        wr(AD_CMP + 6'd10, t[15:8]);
        wait_cnt(t + 16'd2);
        rd(AD_FLG, r); chk("R7 high byte alone no match", r[5], 0);
        rd(AD_CMP + 6'd10, r2); chk("R7 live high byte unchanged", r2, t[15:8] + 8'h0A);
        sched(5, 2'b11, 1'b1, 1'b1, 30);

        // random mix
        for (int n = 0; n < 24; n++) begin
            sched(int'($urandom_range(0, NCH-1)), 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'b1, int'($urandom_range(16, 90)));
        end

        // R8 wrap
        wait_cnt(16'hFFE8);
        sched(6, 2'b01, 1'b1, 1'b1, 64);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule